// File: doc/BRIEF.md
# Hashed Prefix Filter Pipeline

This block is the first stage of a two-stage signature matcher for packet payloads. It takes one payload byte per clock from a byte stream. At each byte position it hashes the most recent `WIN_LEN` bytes of the current packet with the CRC-CCITT polynomial. It uses the low bits of the digest to address a preloaded hash table held in internal RAM. Each table location stores a 24-bit entry and a separate occupied bit. When the addressed location is occupied, the block queues a candidate record in an output FIFO. The record holds the entry's 8-bit pattern tag, its 16-bit start address in the second-stage transition table, and the byte position of the match.

A separate automaton engine pops the candidates and checks the rest of the signature. Digest collisions are therefore harmless false positives. The filter never stalls on a hit. When a record is due and the FIFO is full, the record is dropped and a sticky overflow flag is raised. Software loads the table through a single write port, which can set or clear a location.

Top module: `hpf_top`

## Requirements
- R1: After reset the FIFO is empty, `overflow` is 0 and every table location is unoccupied, so no byte stream produces a record until the table is loaded.
- R2: The digest is CRC-CCITT: polynomial 0x1021, initial value 0xFFFF, each byte fed most significant bit first. It is taken over the last `WIN_LEN` bytes, oldest first, and its low `IDX_W` bits index the table.
- R3: A record carries the tag and start address of the occupied entry. It also carries the zero-based position, within its packet, of the last byte of the hashed window.
- R4: No lookup is made until `WIN_LEN` bytes of the current packet have arrived. A byte accepted with `in_last` ends the packet, so no window spans two packets.
- R5: An unoccupied location produces no record. A write with `tbl_set`=0 clears a location. An all-zero entry written with `tbl_set`=1 is still a hit.
- R6: A record is visible on the FIFO head three clock edges after the edge that accepts the last byte of the window. The pipeline stages are hash, table read, entry check and FIFO push.
- R7: One byte is accepted on every clock edge where `in_valid` is 1. Hits on consecutive bytes each produce a record, in byte order.
- R8: A hit that finds the FIFO full (`FIFO_DEPTH` records) is dropped and sets `overflow`. The flag stays set until reset, and records already stored are delivered intact.
- R9: Cycles with `in_valid`=0 consume no byte and do not disturb the window or the position count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Byte is the final byte of its packet |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W (12) | Table location to write |
| tbl_info | input | 8 | Pattern tag to store |
| tbl_start | input | 16 | Second-stage start address to store |
| tbl_set | input | 1 | 1 marks the location occupied, 0 clears it |
| cand_pop | input | 1 | Remove the FIFO head |
| cand_empty | output | 1 | FIFO holds no record |
| cand_info | output | 8 | Head record pattern tag |
| cand_start | output | 16 | Head record start address |
| cand_pos | output | 16 | Head record match position |
| overflow | output | 1 | Sticky flag for a dropped record |

## Verification
The streams cover several cases:
- A stream with an empty table separates a real lookup from a default hit.
- A stream with two prefixes embedded in filler, one of them an all-zero entry, checks the digest, the tag and the position fields.
- A prefix split across a packet boundary and a packet shorter than the window show whether the window resets.
- The same prefix sent with idle gaps shows whether idle cycles shift the window.
- A run of identical bytes matching a loaded prefix hits on every cycle. It checks back-to-back pushes and, with the consumer paused, overflow and the drop policy.
- A cleared entry and a single timed hit check removal and the three-edge latency.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    localparam int BYTE_W  = 8;
    localparam int INFO_W  = 8;
    localparam int START_W = 16;
    localparam int POS_W   = 16;
    localparam int CRC_W   = 16;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef struct packed {
        logic [INFO_W-1:0]  info;
        logic [START_W-1:0] start;
    } entry_t;

    typedef struct packed {
        entry_t             ent;
        logic [POS_W-1:0]   pos;
    } cand_t;

    // one byte through the CCITT register, msb first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ b[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/hpf_window_hash.sv
module hpf_window_hash
    import hpf_pkg::*;
#(
    parameter int WIN_LEN = 4,
    parameter int IDX_W   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                in_last,
    output logic                s1_valid,
    output logic [IDX_W-1:0]    s1_idx,
    output logic [POS_W-1:0]    s1_pos
);
    localparam int WIN_BITS = WIN_LEN * BYTE_W;
    localparam logic [POS_W-1:0] FIRST_POS = POS_W'(WIN_LEN - 1);
    localparam logic [POS_W-1:0] POS_MAX   = '1;

    logic [WIN_BITS-1:0] win_q, win_n;
    logic [POS_W-1:0]    cnt_q;
    logic [CRC_W-1:0]    digest;

    // newest byte sits in the low lane
    generate
        if (WIN_LEN == 1) begin : g_single
            assign win_n = in_data;
        end else begin : g_shift
            assign win_n = {win_q[WIN_BITS-BYTE_W-1:0], in_data};
        end
    endgenerate

    always_comb begin
        digest = CRC_INIT;
        for (int k = WIN_LEN - 1; k >= 0; k--) begin
            digest = crc_step(digest, win_n[k*BYTE_W +: BYTE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            cnt_q    <= '0;
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_pos   <= '0;
        end else begin
            s1_valid <= in_valid && (cnt_q >= FIRST_POS);
            if (in_valid) begin
                win_q  <= win_n;
                s1_idx <= digest[IDX_W-1:0];
                s1_pos <= cnt_q;
                if (in_last)
                    cnt_q <= '0;
                else if (cnt_q != POS_MAX)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hpf_table.sv
module hpf_table
    import hpf_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  entry_t            wr_entry,
    input  logic              wr_set,
    input  logic [IDX_W-1:0]  rd_addr,
    output entry_t            rd_entry,
    output logic              rd_occ
);
    localparam int DEPTH = 1 << IDX_W;

    entry_t             mem [DEPTH];
    logic [DEPTH-1:0]   occ;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_entry;
        rd_entry <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ    <= '0;
            rd_occ <= 1'b0;
        end else begin
            rd_occ <= occ[rd_addr];
            if (wr_en) occ[wr_addr] <= wr_set;
        end
    end

endmodule

// File: rtl/hpf_fifo.sv
module hpf_fifo
    import hpf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  cand_t                     push_data,
    input  logic                      pop,
    output cand_t                     head,
    output logic                      empty,
    output logic [$clog2(DEPTH):0]    level,
    output logic                      ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    cand_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic           wr_ok, rd_ok;

    assign wr_ok = push && (level != FULL_LVL);
    assign rd_ok = pop && (level != '0);
    assign empty = (level == '0);
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_ok) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && !wr_ok) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/hpf_top.sv
module hpf_top
    import hpf_pkg::*;
#(
    parameter int WIN_LEN    = 4,
    parameter int IDX_W      = 12,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_addr,
    input  logic [7:0]           tbl_info,
    input  logic [15:0]          tbl_start,
    input  logic                 tbl_set,
    input  logic                 cand_pop,
    output logic                 cand_empty,
    output logic [7:0]           cand_info,
    output logic [15:0]          cand_start,
    output logic [15:0]          cand_pos,
    output logic                 overflow
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    logic               s1_valid;
    logic [IDX_W-1:0]   s1_idx;
    logic [POS_W-1:0]   s1_pos;
    logic               s2_valid;
    logic [POS_W-1:0]   s2_pos;
    entry_t             rd_entry;
    logic               rd_occ;
    logic               s3_hit;
    cand_t              s3_rec;
    cand_t              head;
    entry_t             wr_entry;
    logic [LVL_W-1:0]   fifo_level;

    assign wr_entry = '{info: tbl_info, start: tbl_start};

    // stage 1: window and digest
    hpf_window_hash #(.WIN_LEN(WIN_LEN), .IDX_W(IDX_W)) u_hash (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .s1_valid(s1_valid), .s1_idx(s1_idx), .s1_pos(s1_pos)
    );

    // stage 2: table read
    hpf_table #(.IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_entry(wr_entry), .wr_set(tbl_set),
        .rd_addr(s1_idx), .rd_entry(rd_entry), .rd_occ(rd_occ)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_pos   <= '0;
            s3_hit   <= 1'b0;
            s3_rec   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_pos   <= s1_pos;
            // stage 3: entry check
            s3_hit   <= s2_valid && rd_occ;
            s3_rec   <= '{ent: rd_entry, pos: s2_pos};
        end
    end

    // stage 4: queue push
    hpf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(s3_hit), .push_data(s3_rec),
        .pop(cand_pop), .head(head), .empty(cand_empty),
        .level(fifo_level), .ovf(overflow)
    );

    assign cand_info  = head.ent.info;
    assign cand_start = head.ent.start;
    assign cand_pos   = head.pos;

endmodule

// File: rtl/hpf_check.sv
module hpf_check #(
    parameter int WIN_LEN    = 4,
    parameter int FIFO_DEPTH = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          s1_valid,
    input logic [15:0]                   s1_pos,
    input logic                          s3_hit,
    input logic [$clog2(FIFO_DEPTH):0]   fifo_level,
    input logic                          overflow
);
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                            // R8

    AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(fifo_level) == FIFO_DEPTH));            // R8

    AST_GROWTH_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (fifo_level > $past(fifo_level)) |-> $past(s3_hit));               // R5

    AST_WINDOW_FILLED: assert property (@(posedge clk) disable iff (rst)
        s1_valid |-> (s1_pos >= 16'(WIN_LEN - 1)));                        // R4

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= FIFO_DEPTH);                                         // R8

endmodule

bind hpf_top hpf_check #(.WIN_LEN(WIN_LEN), .FIFO_DEPTH(FIFO_DEPTH)) u_check (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_pos(s1_pos),
    .s3_hit(s3_hit), .fifo_level(fifo_level), .overflow(overflow)
);

// File: tb/tb_hpf_top.sv
module tb_hpf_top;
    localparam int L     = 4;
    localparam int IW    = 12;
    localparam int FD    = 8;
    localparam int TSIZE = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic tbl_we = 1'b0, tbl_set = 1'b0;
    logic [IW-1:0] tbl_addr = '0;
    logic [7:0] tbl_info = '0;
    logic [15:0] tbl_start = '0;
    logic cand_pop = 1'b0;
    logic cand_empty, overflow;
    logic [7:0] cand_info;
    logic [15:0] cand_start, cand_pos;

    always #5 clk = ~clk;

    hpf_top #(.WIN_LEN(L), .IDX_W(IW), .FIFO_DEPTH(FD)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_info(tbl_info), .tbl_start(tbl_start),
        .tbl_set(tbl_set), .cand_pop(cand_pop), .cand_empty(cand_empty),
        .cand_info(cand_info), .cand_start(cand_start), .cand_pos(cand_pos),
        .overflow(overflow)
    );

    int vectors = 0;
    int miscompares = 0;
    logic pop_en = 1'b1;
    logic [39:0] exp_q[$];
    bit         m_vld [TSIZE];
    logic [7:0] m_info [TSIZE];
    logic [15:0] m_start [TSIZE];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] w[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (w[j]) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ w[j][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    function automatic logic [IW-1:0] idx_of(input string s);
        logic [7:0] w[$];
        for (int i = 0; i < s.len(); i++) w.push_back(s[i]);
        return IW'(ref_crc(w));
    endfunction

    task automatic load(input string pfx, input logic [7:0] info,
                        input logic [15:0] start, input bit set);
        logic [IW-1:0] ix;
        ix = idx_of(pfx);
        tbl_we = 1'b1; tbl_addr = ix; tbl_info = info; tbl_start = start; tbl_set = set;
        @(negedge clk);
        tbl_we = 1'b0;
        m_vld[ix] = set; m_info[ix] = info; m_start[ix] = start;
    endtask

    // driver: one packet, model predicts records
    task automatic send_pkt(input string s, input bit gaps, input bit last);
        logic [7:0] w[$];
        for (int i = 0; i < s.len(); i++) begin
            in_valid = 1'b1; in_data = s[i]; in_last = last && (i == s.len() - 1);
            @(negedge clk);
            w.push_back(s[i]);
            if (w.size() > L) void'(w.pop_front());
            if (w.size() == L) begin
                logic [IW-1:0] ix;
                ix = IW'(ref_crc(w));
                if (m_vld[ix]) begin
                    if (!(!pop_en && exp_q.size() >= FD))
                        exp_q.push_back({m_info[ix], m_start[ix], 16'(i)});
                end
            end
            in_valid = 1'b0; in_last = 1'b0;
            if (gaps) begin
                in_data = 8'hA5;
                repeat (2) @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        repeat (6) @(negedge clk);
        while ((exp_q.size() != 0 || !cand_empty) && t < 200) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && cand_empty, req, "queue drained",
              40'(exp_q.size()), 40'd0);
    endtask

    // monitor: pops and compares against scoreboard
    always @(negedge clk) begin
        cand_pop = 1'b0;
        if (!rst && pop_en && !cand_empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 R5", "unexpected record",
                      {cand_info, cand_start, cand_pos}, 40'd0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                check({cand_info, cand_start, cand_pos} == e, "R2 R3 R7",
                      "record", {cand_info, cand_start, cand_pos}, e);
            end
            cand_pop = 1'b1;
        end
    end

    initial begin
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        foreach (m_vld[i]) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state and empty table
        check(cand_empty == 1'b1, "R1", "empty after reset", 40'(cand_empty), 40'd1);
        check(overflow == 1'b0, "R1", "overflow after reset", 40'(overflow), 40'd0);
        send_pkt("zLOGIxATTKAAAAAy", 1'b0, 1'b1);
        drain("R1");

        // R2 R3 R5: two prefixes, one all-zero entry
        load("LOGI", 8'h11, 16'h1234, 1'b1);
        load("ATTK", 8'h00, 16'h0000, 1'b1);
        send_pkt("xxLOGIyyATTKz", 1'b0, 1'b1);
        drain("R2");

        // R4: split across packets and a short packet
        send_pkt("qqLO", 1'b0, 1'b1);
        send_pkt("GIqq", 1'b0, 1'b1);
        send_pkt("LOG", 1'b0, 1'b1);
        drain("R4");

        // R9: idle gaps inside a packet
        send_pkt("aLOGIb", 1'b1, 1'b1);
        drain("R9");

        // R7: hit on every cycle
        load("AAAA", 8'h5A, 16'hBEEF, 1'b1);
        send_pkt("LOGILOGIAAAAAAA", 1'b0, 1'b1);
        drain("R7");

        // R5: cleared entry gives nothing
        load("ATTK", 8'h00, 16'h0000, 1'b0);
        send_pkt("rATTKr", 1'b0, 1'b1);
        drain("R5");

        // R6: latency of a single hit
        pop_en = 1'b0;
        send_pkt("LOG", 1'b0, 1'b0);
        in_valid = 1'b1; in_data = "I"; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        exp_q.push_back({8'h11, 16'h1234, 16'd3});
        check(cand_empty == 1'b1, "R6", "empty one edge after", 40'(cand_empty), 40'd1);
        @(negedge clk);
        check(cand_empty == 1'b1, "R6", "empty two edges after", 40'(cand_empty), 40'd1);
        @(negedge clk);
        check(cand_empty == 1'b1, "R6", "empty three edges... pre-push", 40'(cand_empty), 40'd1);
        @(negedge clk);
        check(cand_empty == 1'b0, "R6", "record after push edge", 40'(cand_empty), 40'd0);
        pop_en = 1'b1;
        drain("R6");

        // R8: overflow with consumer paused
        pop_en = 1'b0;
        send_pkt("AAAAAAAAAAAAAAAA", 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow raised", 40'(overflow), 40'd1);
        check(exp_q.size() == FD, "R8", "model keeps depth", 40'(exp_q.size()), 40'(FD));
        pop_en = 1'b1;
        drain("R8");
        check(overflow == 1'b1, "R8", "overflow sticky", 40'(overflow), 40'd1);

        // R1 R8: reset clears flag and table
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        foreach (m_vld[i]) m_vld[i] = 1'b0;
        @(negedge clk);
        check(overflow == 1'b0, "R8", "overflow cleared by reset", 40'(overflow), 40'd0);
        check(cand_empty == 1'b1, "R1", "empty after second reset", 40'(cand_empty), 40'd1);
        send_pkt("AAAALOGI", 1'b0, 1'b1);
        drain("R1");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule